// File: doc/BRIEF.md
# Memory Domain Access Permission Checker

This block decides whether a memory access may proceed, based on the domain it falls in. It holds one control word that splits into a 2-bit permission code for each memory domain. For every access, the translation logic supplies three inputs: the domain number of the translated page, the verdict of the page-level permission check, and a bit that says whether the long-descriptor table format is active. The block returns an allow flag and a domain-fault flag in the same cycle.

Each domain code has one of four meanings:

- **Deny:** every access faults.
- **Client:** the access defers to the page verdict.
- **Bypass:** the access is allowed without looking at the page verdict.
- **Reserved:** handled exactly like deny, so that a corrupt setting never opens memory.

When the long-descriptor format is selected, domains play no part. The page verdict passes straight through and no domain fault is raised.

Software-side logic writes the control word through a synchronous write port and reads it back on a read port. The word resets to a parameterised value. By default that value is all zeros, which puts every domain in the deny state.

Top module: `dom_access_checker`

## Requirements
- R1: After reset, `cfg_rd_data` equals the reset word, which is zero by default. With the default reset word, any short-format access raises a domain fault.
- R2: A rising clock edge with `cfg_wr_en` high loads `cfg_wr_data` into the control word, and `cfg_rd_data` shows the new value after that edge. With `cfg_wr_en` low, the word and `cfg_rd_data` keep their value whatever `cfg_wr_data` carries.
- R3: The code of domain n sits in bits [2n+1:2n] of the control word, for n = 0 to 15.
- R4: Code 2'b00 (deny) in short format gives `acc_allow`=0 and `acc_dom_fault`=1, whatever `acc_pt_ok` is.
- R5: Code 2'b01 (client) in short format gives `acc_allow`=`acc_pt_ok` and `acc_dom_fault`=0.
- R6: Code 2'b11 (bypass) in short format gives `acc_allow`=1 and `acc_dom_fault`=0, even when `acc_pt_ok` is 0.
- R7: Code 2'b10 (reserved) in short format gives `acc_allow`=0 and `acc_dom_fault`=1, whatever `acc_pt_ok` is.
- R8: With `acc_long_fmt`=1, `acc_allow` equals `acc_pt_ok` and `acc_dom_fault` is 0, whatever the control word holds.
- R9: The decision is combinational from the access inputs and the stored word. During the cycle in which a write is presented, the decision still uses the old word. The new word governs from the cycle after the write edge.
- R10: `acc_allow` and `acc_dom_fault` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Value to store in the control word |
| cfg_rd_data | output | 32 | Current control word |
| acc_domain | input | 4 | Domain number of the access |
| acc_pt_ok | input | 1 | Page permission check passed |
| acc_long_fmt | input | 1 | Long-descriptor format in use; domains ignored |
| acc_allow | output | 1 | Access may proceed |
| acc_dom_fault | output | 1 | Access fails with a domain fault |

## Verification
The bench builds the block with its default parameters: sixteen domains, 2-bit codes and a reset word of zero. These values make every index of the 4-bit domain input select a real field, so each field position can be checked against its neighbours. They also give a known all-deny state straight out of reset. A set of eight control words places every code in every domain. Each word is swept across all domains, both page verdicts and both format modes, and the results are compared with a model written from the requirements. Directed cases then probe the write-visibility edge and writes with the strobe held low.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

   typedef enum logic [1:0] {
      PERM_DENY   = 2'b00,
      PERM_CLIENT = 2'b01,
      PERM_RSVD   = 2'b10,
      PERM_BYPASS = 2'b11
   } perm_code_e;

endpackage

// File: rtl/dacc_ctrl_reg.sv
module dacc_ctrl_reg #(
   parameter int               WORD_W  = 32,
   parameter logic [WORD_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] q
);

   if (WORD_W < 2) begin : g_bad_width
      $error("dacc_ctrl_reg: WORD_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST_VAL;
      else if (wr_en) q <= wr_data;
   end

endmodule

// File: rtl/dacc_code_mux.sv
module dacc_code_mux #(
   parameter int  NUM_DOM = 16,
   parameter int  CODE_W  = 2,
   localparam int WORD_W  = NUM_DOM * CODE_W,
   localparam int IDX_W   = $clog2(NUM_DOM)
) (
   input  logic [WORD_W-1:0] word,
   input  logic [IDX_W-1:0]  idx,
   output logic [CODE_W-1:0] code
);

   if (NUM_DOM < 2 || (1 << IDX_W) != NUM_DOM) begin : g_bad_count
      $error("dacc_code_mux: NUM_DOM must be a power of two, at least 2");
   end

   logic [CODE_W-1:0] fields [NUM_DOM];

   // Field g of the word sits at bits [g*CODE_W +: CODE_W].
   for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
      assign fields[g] = word[g*CODE_W +: CODE_W];
   end

   assign code = fields[idx];

endmodule

// File: rtl/dacc_verdict.sv
module dacc_verdict
   import dacc_pkg::*;
(
   input  perm_code_e code,
   input  logic       pt_ok,
   input  logic       long_fmt,
   output logic       allow,
   output logic       fault
);

   always_comb begin
      allow = 1'b0;
      fault = 1'b0;
      if (long_fmt) begin
         allow = pt_ok;
      end else begin
         unique case (code)
            PERM_CLIENT: allow = pt_ok;
            PERM_BYPASS: allow = 1'b1;
            PERM_DENY,
            PERM_RSVD:   fault = 1'b1;
            default:     fault = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/dom_access_checker.sv
module dom_access_checker
   import dacc_pkg::*;
#(
   parameter int                NUM_DOM  = 16,
   parameter int                CODE_W   = 2,
   localparam int               WORD_W   = NUM_DOM * CODE_W,
   localparam int               IDX_W    = $clog2(NUM_DOM),
   parameter logic [WORD_W-1:0] RST_WORD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [WORD_W-1:0] cfg_wr_data,
   output logic [WORD_W-1:0] cfg_rd_data,
   input  logic [IDX_W-1:0]  acc_domain,
   input  logic              acc_pt_ok,
   input  logic              acc_long_fmt,
   output logic              acc_allow,
   output logic              acc_dom_fault
);

   if (CODE_W != $bits(perm_code_e)) begin : g_bad_code_w
      $error("dom_access_checker: CODE_W must match the permission code width");
   end

   logic [WORD_W-1:0] ctrl_word;
   logic [CODE_W-1:0] raw_code;
   perm_code_e        sel_code;

   dacc_ctrl_reg #(
      .WORD_W  (WORD_W),
      .RST_VAL (RST_WORD)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_data (cfg_wr_data),
      .q       (ctrl_word)
   );

   assign cfg_rd_data = ctrl_word;

   dacc_code_mux #(
      .NUM_DOM (NUM_DOM),
      .CODE_W  (CODE_W)
   ) u_mux (
      .word (ctrl_word),
      .idx  (acc_domain),
      .code (raw_code)
   );

   assign sel_code = perm_code_e'(raw_code);

   dacc_verdict u_verdict (
      .code     (sel_code),
      .pt_ok    (acc_pt_ok),
      .long_fmt (acc_long_fmt),
      .allow    (acc_allow),
      .fault    (acc_dom_fault)
   );

   // A strobed write lands in the word after the edge (R2).
   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data));

   // Without the strobe the word holds (R2).
   assert_word_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr_en |=> $stable(cfg_rd_data));

   // Fault and allow are exclusive (R10).
   assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_allow && acc_dom_fault));

   // Long format hides domains entirely (R8).
   assert_long_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_long_fmt |-> (!acc_dom_fault && acc_allow == acc_pt_ok));

   // Bypass code in short format always allows (R6).
   assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_long_fmt && sel_code == PERM_BYPASS) |-> acc_allow);

   // Reserved code in short format faults (R7).
   assert_rsvd_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_long_fmt && sel_code == PERM_RSVD) |-> (acc_dom_fault && !acc_allow));

endmodule

// File: tb/dom_access_checker_tb_top.sv
module dom_access_checker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [31:0] cfg_wr_data = '0;
   logic [31:0] cfg_rd_data;
   logic [3:0]  acc_domain = '0;
   logic        acc_pt_ok = 1'b0;
   logic        acc_long_fmt = 1'b0;
   logic        acc_allow;
   logic        acc_dom_fault;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   dom_access_checker dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_wr_en     (cfg_wr_en),
      .cfg_wr_data   (cfg_wr_data),
      .cfg_rd_data   (cfg_rd_data),
      .acc_domain    (acc_domain),
      .acc_pt_ok     (acc_pt_ok),
      .acc_long_fmt  (acc_long_fmt),
      .acc_allow     (acc_allow),
      .acc_dom_fault (acc_dom_fault)
   );

   localparam logic [31:0] WORDS [8] = '{
      32'h0000_0000, 32'h5555_5555, 32'hAAAA_AAAA, 32'hFFFF_FFFF,
      32'h1B1B_1B1B, 32'hE4E4_E4E4, 32'h8D72_36C9, 32'h72D8_C936
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Model from R4..R8: returns {allow, fault}.
   function automatic logic [1:0] model(input logic [31:0] w, input int d,
                                        input logic pt, input logic lf);
      logic [1:0] c;
      c = w[2*d +: 2];
      if (lf)            return {pt, 1'b0};
      if (c == 2'b01)    return {pt, 1'b0};
      if (c == 2'b11)    return 2'b10;
      return 2'b01;
   endfunction

   function automatic string req_of(input logic [31:0] w, input int d, input logic lf);
      logic [1:0] c;
      c = w[2*d +: 2];
      if (lf) return "R8";
      case (c)
         2'b00:   return "R4";
         2'b01:   return "R5";
         2'b10:   return "R7";
         default: return "R6";
      endcase
   endfunction

   task automatic write_word(input logic [31:0] w);
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_data = w;
      @(negedge clk);
      cfg_wr_en   = 1'b0;
      #1;
      check("R2 write", cfg_rd_data, w);
   endtask

   task automatic probe(input int d, input logic pt, input logic lf,
                        input logic [31:0] w, input string req);
      acc_domain   = 4'(d);
      acc_pt_ok    = pt;
      acc_long_fmt = lf;
      #1;
      check(req, {30'd0, acc_allow, acc_dom_fault}, {30'd0, model(w, d, pt, lf)});
      check("R10 excl", {31'd0, acc_allow & acc_dom_fault}, 32'd0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset word zero, short-format access faults.
      check("R1 reset word", cfg_rd_data, 32'd0);
      probe(9, 1'b1, 1'b0, 32'd0, "R1 reset deny");

      // Vector table walk: all domains, verdicts and modes (R3..R8).
      for (int k = 0; k < 8; k++) begin
         write_word(WORDS[k]);
         for (int d = 0; d < 16; d++)
            for (int p = 0; p < 2; p++)
               for (int l = 0; l < 2; l++)
                  probe(d, 1'(p), 1'(l), WORDS[k], req_of(WORDS[k], d, 1'(l)));
      end

      // R3: a single bypass field at domain 7, neighbours deny.
      write_word(32'h0000_C000);
      probe(7, 1'b0, 1'b0, 32'h0000_C000, "R3 field 7");
      probe(6, 1'b1, 1'b0, 32'h0000_C000, "R3 field 6");
      probe(8, 1'b1, 1'b0, 32'h0000_C000, "R3 field 8");

      // R2: data changes with strobe low leave the word alone.
      @(negedge clk);
      cfg_wr_data = 32'hFFFF_FFFF;
      @(negedge clk);
      @(negedge clk);
      #1;
      check("R2 no strobe", cfg_rd_data, 32'h0000_C000);
      probe(3, 1'b0, 1'b0, 32'h0000_C000, "R2 no strobe decision");

      // R9: write visible only after the edge.
      @(negedge clk);
      acc_domain   = 4'd3;
      acc_pt_ok    = 1'b0;
      acc_long_fmt = 1'b0;
      cfg_wr_en    = 1'b1;
      cfg_wr_data  = 32'hFFFF_FFFF;
      #1;
      check("R9 before edge", {30'd0, acc_allow, acc_dom_fault}, 32'd1);
      @(negedge clk);
      cfg_wr_en = 1'b0;
      #1;
      check("R9 after edge", {30'd0, acc_allow, acc_dom_fault}, 32'd2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule